// File: doc/BRIEF.md
# Vectored Interrupt Arbitration Unit

This unit sits next to a small 8-bit processor core and decides when and where the core diverts into an interrupt handler. Peripherals post requests by vector index. The unit holds them in a pending set and, at each permitted check point, selects the eligible request with the lowest vector address. It then either resets the core, or it drives the entry sequence. That sequence clears the core's global enable, pushes the return address onto the stack one byte at a time, and loads the handler address into the program counter.

Vector index `i` sits at word address `i * VEC_STRIDE`. Index 0 is the reset vector. Check points are the end of every instruction (`insn_done`) and every cycle in which the core is asleep. While asleep, a request counts only if its wake mask overlaps the current one-hot sleep mode. A check point that ends a return-from-interrupt is skipped, so that one more instruction runs first.

The return-address bytes leave on a valid/ready stream. `stk_valid` rises when the push sequence starts. The byte and `stk_valid` are held steady until `stk_ready` is seen high at a clock edge, and only then does the next byte appear. Back-pressure stalls the sequence for any number of cycles. All other pins are plain level or one-cycle strobe signals.

Top module: `irq_vector_unit`

## Requirements
- R1: `raise_valid` sets pending bit `raise_idx` at the next edge, and raising a bit that is already set changes nothing. `clr_valid` clears bit `clr_idx`. When a raise and a clear name the same bit in the same cycle, the bit ends up set.
- R2: When several eligible requests are pending, the one with the lowest index (that is, the lowest vector address) wins.
- R3: While `sleeping` is high, a non-reset request `i` is eligible only if `wake_mask[i*SLEEP_W +: SLEEP_W] & sleep_mode` is non-zero. Otherwise the next higher index is considered. While awake, every pending request is eligible.
- R4: If the winner is index 0, `core_reset` pulses for one cycle after the check edge whatever `gie` is, and the whole pending set is cleared, including a raise in that same cycle.
- R5: A maskable winner is serviced only if `gie` is high at the check point. Otherwise nothing happens and the request stays pending.
- R6: When service starts, `gie_clr` pulses for one cycle, `busy` rises, and the winner's pending bit is cleared, all on the same edge. No new check is made while `busy` is high.
- R7: The return address `cur_pc` (latched at the check point) is pushed as PC_BYTES bytes: 2 when PC_W is 16 or less, 3 otherwise. The low byte goes first and the high byte last, and each byte is held under back-pressure.
- R8: One cycle after the last byte is accepted, `pc_load` pulses with `pc_new = (vec_base + idx*VEC_STRIDE) mod PROG_WORDS`. `busy` falls on the following edge.
- R9: An `insn_done` with `insn_was_reti` high makes no check. Sleep-state checks are also suppressed until the next `insn_done`, and that later boundary does check.
- R10: Checks happen only on an `insn_done` cycle or on a cycle with `sleeping` high, and never while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raise_valid | input | 1 | Post a request |
| raise_idx | input | clog2(NUM_VEC) | Vector index to post |
| clr_valid | input | 1 | Withdraw a request |
| clr_idx | input | clog2(NUM_VEC) | Vector index to withdraw |
| wake_mask | input | NUM_VEC*SLEEP_W | Per-vector sleep modes that the vector may wake from |
| sleeping | input | 1 | Core is in the sleep state |
| sleep_mode | input | SLEEP_W | One-hot current sleep mode |
| gie | input | 1 | Core's global interrupt enable bit |
| insn_done | input | 1 | An instruction completed this cycle |
| insn_was_reti | input | 1 | That instruction was a return-from-interrupt |
| cur_pc | input | PC_W | Current program counter (return address) |
| vec_base | input | PC_W | Vector base offset in words |
| pending | output | NUM_VEC | Pending request set |
| gie_clr | output | 1 | Strobe: clear the global enable |
| core_reset | output | 1 | Strobe: reset the core |
| busy | output | 1 | Entry sequence in progress |
| stk_valid | output | 1 | Stack byte valid |
| stk_ready | input | 1 | Stack accepts byte |
| stk_data | output | 8 | Stack byte |
| pc_load | output | 1 | Strobe: load `pc_new` into the PC |
| pc_new | output | PC_W | Handler address |

## Verification
Some rules concern local relations between ports, and the bound checker tests these on every cycle. They are: a raise shows up in the pending set, a reset strobe comes with an empty set, `gie_clr` only follows a high `gie`, a stalled byte stays put, `pc_load` stays in range and closes the busy window, and a reti boundary produces no entry. The directed scenarios are needed for the rules that depend on the whole history: which of several requests wins, how the sleep mask lets a higher index win over a lower one, the exact byte order, the wrapped handler address, and the deferred service after a return-from-interrupt.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
  typedef enum logic [1:0] {PS_IDLE, PS_PUSH, PS_LOAD} push_st_e;

  function automatic int pc_bytes(input int pc_w);
    return (pc_w > 16) ? 3 : 2;
  endfunction
endpackage

// File: rtl/ivu_pending_set.sv
module ivu_pending_set #(
  parameter int NUM_VEC = 16,
  localparam int IW = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_v,
  input  logic [IW-1:0]      set_i,
  input  logic               clr_v,
  input  logic [IW-1:0]      clr_i,
  input  logic               take_v,
  input  logic [IW-1:0]      take_i,
  input  logic               flush,
  output logic [NUM_VEC-1:0] bits
);
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_bit
    logic hit_set, hit_drop;
    assign hit_set  = set_v && (set_i == IW'(g));
    assign hit_drop = (clr_v && (clr_i == IW'(g))) || (take_v && (take_i == IW'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bits[g] <= 1'b0;
      else if (flush)    bits[g] <= 1'b0;
      else if (hit_set)  bits[g] <= 1'b1;
      else if (hit_drop) bits[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/ivu_select.sv
module ivu_select #(
  parameter int NUM_VEC = 16,
  parameter int SLEEP_W = 4,
  localparam int IW = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0]         req,
  input  logic [NUM_VEC*SLEEP_W-1:0] wake_mask,
  input  logic                       sleeping,
  input  logic [SLEEP_W-1:0]         sleep_mode,
  output logic                       found,
  output logic [IW-1:0]              win
);
  logic [NUM_VEC-1:0] elig;

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_elig
    if (g == 0) begin : g_rst
      assign elig[g] = req[g];
    end else begin : g_mask
      assign elig[g] = req[g] &&
        (!sleeping || |(wake_mask[g*SLEEP_W +: SLEEP_W] & sleep_mode));
    end
  end

  always_comb begin
    found = |elig;
    win   = '0;
    for (int k = NUM_VEC - 1; k >= 0; k--) begin
      if (elig[k]) win = IW'(k);
    end
  end
endmodule

// File: rtl/ivu_push_seq.sv
module ivu_push_seq import ivu_pkg::*; #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [PC_W-1:0] ret_pc,
  input  logic [PC_W-1:0] target,
  input  logic            stk_ready,
  output logic            stk_valid,
  output logic [7:0]      stk_data,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_new,
  output logic            busy
);
  localparam int NB = pc_bytes(PC_W);
  localparam int SW = NB * 8;

  push_st_e        st;
  logic [1:0]      cnt;
  logic [SW-1:0]   ret_q;
  logic [PC_W-1:0] tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= PS_IDLE;
      cnt   <= '0;
      ret_q <= '0;
      tgt_q <= '0;
    end else begin
      case (st)
        PS_IDLE: if (start) begin
          st    <= PS_PUSH;
          cnt   <= '0;
          ret_q <= SW'(ret_pc);
          tgt_q <= target;
        end
        PS_PUSH: if (stk_ready) begin
          if (cnt == 2'(NB - 1)) st <= PS_LOAD;
          else cnt <= cnt + 2'd1;
        end
        default: st <= PS_IDLE;
      endcase
    end
  end

  assign stk_valid = (st == PS_PUSH);
  assign stk_data  = ret_q[8*cnt +: 8];
  assign pc_load   = (st == PS_LOAD);
  assign pc_new    = tgt_q;
  assign busy      = (st != PS_IDLE);
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int NUM_VEC    = 16,
  parameter int SLEEP_W    = 4,
  parameter int PC_W       = 16,
  parameter int PROG_WORDS = 4096,
  parameter int VEC_STRIDE = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         raise_valid,
  input  logic [$clog2(NUM_VEC)-1:0]   raise_idx,
  input  logic                         clr_valid,
  input  logic [$clog2(NUM_VEC)-1:0]   clr_idx,
  input  logic [NUM_VEC*SLEEP_W-1:0]   wake_mask,
  input  logic                         sleeping,
  input  logic [SLEEP_W-1:0]           sleep_mode,
  input  logic                         gie,
  input  logic                         insn_done,
  input  logic                         insn_was_reti,
  input  logic [PC_W-1:0]              cur_pc,
  input  logic [PC_W-1:0]              vec_base,
  output logic [NUM_VEC-1:0]           pending,
  output logic                         gie_clr,
  output logic                         core_reset,
  output logic                         busy,
  output logic                         stk_valid,
  input  logic                         stk_ready,
  output logic [7:0]                   stk_data,
  output logic                         pc_load,
  output logic [PC_W-1:0]              pc_new
);
  localparam int IW = $clog2(NUM_VEC);

  logic          found, hold_q, check_pt, do_reset, do_start;
  logic [IW-1:0] win;
  logic [PC_W-1:0] target;

  // A reti boundary makes no check; sleep checks wait for the next boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hold_q <= 1'b0;
    else if (insn_done) hold_q <= insn_was_reti;
  end

  assign check_pt = !busy && (insn_done ? !insn_was_reti : (sleeping && !hold_q));
  assign do_reset = check_pt && found && (win == '0);
  assign do_start = check_pt && found && (win != '0) && gie;
  assign target   = PC_W'((32'(vec_base) + 32'(win) * VEC_STRIDE) % PROG_WORDS);

  ivu_pending_set #(.NUM_VEC(NUM_VEC)) u_set (
    .clk(clk), .rst_n(rst_n),
    .set_v(raise_valid), .set_i(raise_idx),
    .clr_v(clr_valid), .clr_i(clr_idx),
    .take_v(do_start), .take_i(win),
    .flush(do_reset), .bits(pending)
  );

  ivu_select #(.NUM_VEC(NUM_VEC), .SLEEP_W(SLEEP_W)) u_sel (
    .req(pending), .wake_mask(wake_mask), .sleeping(sleeping),
    .sleep_mode(sleep_mode), .found(found), .win(win)
  );

  ivu_push_seq #(.PC_W(PC_W)) u_push (
    .clk(clk), .rst_n(rst_n), .start(do_start), .ret_pc(cur_pc),
    .target(target), .stk_ready(stk_ready), .stk_valid(stk_valid),
    .stk_data(stk_data), .pc_load(pc_load), .pc_new(pc_new), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_clr    <= 1'b0;
      core_reset <= 1'b0;
    end else begin
      gie_clr    <= do_start;
      core_reset <= do_reset;
    end
  end
endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk #(
  parameter int NUM_VEC    = 16,
  parameter int PC_W       = 16,
  parameter int PROG_WORDS = 4096
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       raise_valid,
  input logic [$clog2(NUM_VEC)-1:0] raise_idx,
  input logic                       gie,
  input logic                       insn_done,
  input logic                       insn_was_reti,
  input logic [NUM_VEC-1:0]         pending,
  input logic                       gie_clr,
  input logic                       core_reset,
  input logic                       busy,
  input logic                       stk_valid,
  input logic                       stk_ready,
  input logic [7:0]                 stk_data,
  input logic                       pc_load,
  input logic [PC_W-1:0]            pc_new
);
  a_r1_raise_lands: assert property (@(posedge clk) disable iff (!rst_n)
    raise_valid |=> (pending[$past(raise_idx)] || core_reset));

  a_r4_reset_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |-> (pending == '0));

  a_r6_gie_needed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gie_clr) |-> ($past(gie) && busy));

  a_r7_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid && !stk_ready) |=> (stk_valid && $stable(stk_data)));

  a_r8_load_range: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (busy && !stk_valid && (int'(pc_new) < PROG_WORDS)));

  a_r8_load_ends: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !busy);

  a_r9_reti_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && insn_was_reti) |=> (!gie_clr && !core_reset));

  a_r10_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gie_clr, core_reset, pc_load}));
endmodule

bind irq_vector_unit irq_vector_chk #(
  .NUM_VEC(NUM_VEC), .PC_W(PC_W), .PROG_WORDS(PROG_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .raise_valid(raise_valid), .raise_idx(raise_idx),
  .gie(gie), .insn_done(insn_done), .insn_was_reti(insn_was_reti),
  .pending(pending), .gie_clr(gie_clr), .core_reset(core_reset), .busy(busy),
  .stk_valid(stk_valid), .stk_ready(stk_ready), .stk_data(stk_data),
  .pc_load(pc_load), .pc_new(pc_new)
);

// File: tb/tb_irq_vector_unit.sv
module tb_irq_vector_unit;
  localparam int NV = 16, SW = 4, PW = 16, PWORDS = 4096, STRIDE = 2;

  logic clk = 0, rst_n = 0;
  logic raise_valid = 0, clr_valid = 0;
  logic [3:0] raise_idx = '0, clr_idx = '0;
  logic [NV*SW-1:0] wake_mask = '0;
  logic sleeping = 0, gie = 0, insn_done = 0, insn_was_reti = 0, stk_ready = 1;
  logic [SW-1:0] sleep_mode = '0;
  logic [PW-1:0] cur_pc = '0, vec_base = '0;
  logic [NV-1:0] pending;
  logic gie_clr, core_reset, busy, stk_valid, pc_load;
  logic [7:0] stk_data;
  logic [PW-1:0] pc_new;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  irq_vector_unit #(.NUM_VEC(NV), .SLEEP_W(SW), .PC_W(PW),
    .PROG_WORDS(PWORDS), .VEC_STRIDE(STRIDE)) dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic raise(input int i);
    raise_valid = 1; raise_idx = 4'(i); tick(); raise_valid = 0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < NV; i++) begin
      clr_valid = 1; clr_idx = 4'(i); tick();
    end
    clr_valid = 0;
  endtask

  // Called on the first negedge after the check edge.
  task automatic expect_entry(input int idx, input int tgt, input string tag);
    chk(gie_clr && busy, {tag, " R6 gie_clr/busy"}, {gie_clr, busy}, 3);
    chk(!pending[idx], {tag, " R6 bit taken"}, pending, idx);
    chk(stk_valid && stk_data == cur_pc[7:0], {tag, " R7 low byte"}, stk_data, cur_pc[7:0]);
    tick();
    chk(!gie_clr, {tag, " R6 single pulse"}, gie_clr, 0);
    chk(stk_valid && stk_data == cur_pc[15:8], {tag, " R7 high byte"}, stk_data, cur_pc[15:8]);
    tick();
    chk(pc_load && !stk_valid && pc_new == PW'(tgt), {tag, " R8 load"}, pc_new, tgt);
    tick();
    chk(!busy && !pc_load, {tag, " R8 idle"}, busy, 0);
  endtask

  task automatic t_reset_state();
    chk(pending == 0 && !busy && !stk_valid && !gie_clr && !core_reset && !pc_load,
        "R10 reset state", {pending, busy, stk_valid}, 0);
  endtask

  task automatic t_pending_set();
    raise(5); raise(3); raise(5);
    chk(pending == 16'h0028, "R1 raise twice", pending, 16'h0028);
    raise_valid = 1; raise_idx = 3; clr_valid = 1; clr_idx = 3; tick();
    raise_valid = 0; clr_valid = 0;
    chk(pending == 16'h0028, "R1 raise beats clear", pending, 16'h0028);
    clr_valid = 1; clr_idx = 5; tick(); clr_valid = 0;
    chk(pending == 16'h0008, "R1 clear", pending, 16'h0008);
    clear_all();
  endtask

  task automatic t_priority();
    raise(7); raise(5); raise(3);
    vec_base = 16'h0040; cur_pc = 16'h1234; gie = 1;
    insn_done = 1; tick(); insn_done = 0;
    expect_entry(3, 16'h0046, "prio R2");
    chk(pending == 16'h00A0, "R2 others remain", pending, 16'h00A0);
    gie = 0; clear_all();
  endtask

  task automatic t_gie_off();
    raise(4); gie = 0;
    insn_done = 1; tick(); insn_done = 0; tick();
    chk(!busy && !gie_clr && pending == 16'h0010, "R5 masked", pending, 16'h0010);
    clear_all();
  endtask

  task automatic t_sleep();
    wake_mask = '0;
    wake_mask[5*SW +: SW] = 4'b0001;
    wake_mask[7*SW +: SW] = 4'b0010;
    raise(5); raise(7);
    vec_base = 16'h0100; cur_pc = 16'hBEEF; gie = 1;
    sleeping = 1; sleep_mode = 4'b0100; tick(); tick();
    chk(!busy && pending == 16'h00A0, "R3 no wake", pending, 16'h00A0);
    sleep_mode = 4'b0010; tick();
    expect_entry(7, 16'h010E, "sleep R3");
    tick(); tick();
    chk(!busy && pending == 16'h0020, "R3 vec5 still masked", pending, 16'h0020);
    sleeping = 0; tick();
    chk(!busy, "R10 awake no boundary", busy, 0);
    gie = 0; sleep_mode = '0; clear_all();
  endtask

  task automatic t_wrap_backpressure();
    raise(5); vec_base = 16'(PWORDS - 6); cur_pc = 16'hA55A; gie = 1;
    stk_ready = 0; insn_done = 1; tick(); insn_done = 0;
    chk(stk_valid && stk_data == 8'h5A, "R7 first byte", stk_data, 8'h5A);
    tick(); tick();
    chk(stk_valid && stk_data == 8'h5A, "R7 held under stall", stk_data, 8'h5A);
    stk_ready = 1; tick();
    chk(stk_valid && stk_data == 8'hA5, "R7 second byte", stk_data, 8'hA5);
    tick();
    chk(pc_load && pc_new == 16'd4, "R8 wrapped target", pc_new, 4);
    tick(); gie = 0; clear_all();
  endtask

  task automatic t_reti_holdoff();
    raise(6); vec_base = 0; cur_pc = 16'h0321; gie = 1;
    insn_done = 1; insn_was_reti = 1; tick(); insn_done = 0; insn_was_reti = 0;
    chk(!gie_clr && !busy, "R9 reti boundary skipped", busy, 0);
    sleeping = 1; sleep_mode = 4'b1111; wake_mask[6*SW +: SW] = 4'b1111; tick();
    chk(!busy && pending[6], "R9 sleep check held", pending, 16'h0040);
    sleeping = 0; insn_done = 1; tick(); insn_done = 0;
    expect_entry(6, 12, "reti R9");
    gie = 0; sleep_mode = '0; clear_all();
  endtask

  task automatic t_reset_vector();
    raise(4); raise(0); gie = 0;
    insn_done = 1; tick(); insn_done = 0;
    chk(core_reset && !busy, "R4 reset despite gie", core_reset, 1);
    chk(pending == 0, "R4 flush", pending, 0);
    tick();
    chk(!core_reset, "R4 single pulse", core_reset, 0);
  endtask

  initial begin
    #1ms;
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    t_reset_state();
    t_pending_set();
    t_priority();
    t_gie_off();
    t_sleep();
    t_wrap_backpressure();
    t_reti_holdoff();
    t_reset_vector();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule